// File: doc/BRIEF.md
# Two-Wire Configuration Register Slave

This block is a serial slave on a two-wire SMBus/I2C-compatible bus. It gives a bus controller write and read access to a small bank of byte-wide configuration registers. Register 0 drives the control outputs of a clock generator: one enable for each of the two clock output pairs, a spread-spectrum enable, and a bit that selects the spread depth. The block does not model the PLL or the output drivers.

A transfer begins with the address byte, then a command byte. Bit 7 of the command selects the access type. Set, it requests a single access to the register whose index is in bits 4:0. Clear, it requests a sequential block access that always starts at register 0. Bits 6:5 must be zero for the device to respond. A block write carries a byte count ahead of its data. A block read returns the register count first, then the registers from index 0 upward.

SCL and SDA are sampled through a two-flop synchronizer in a system clock that runs at least eight times faster than SCL. The slave drives SDA only by pulling it low, through `sda_oe`. All registers load their defaults at reset, so software does not need to use the interface at all.

Top module: `smb_cfg_slave`

## Requirements
- R1: The slave ACKs the address byte 0xD2 (write) or 0xD3 (read), which is 7-bit address 0x69 with the R/W bit in bit 0. It NACKs any other address, and it then leaves SDA released until the next START or STOP.
- R2: Command bit 7 = 1 selects single-byte access at the offset in bits 4:0. Command bit 7 = 0 selects block access from register 0, and bits 4:0 are then ignored.
- R3: A command whose bits 6:5 are not 00 is NACKed. The bytes that follow it are NACKed and change no register.
- R4: A single-byte write stores one data byte at the offset and ACKs it. A second data byte in the same transfer is NACKed and not stored. An offset at or beyond the register count makes the data byte NACKed.
- R5: In a block write the byte after the command is a count and is ACKed. The data bytes that follow go to registers 0, 1, 2 and so on, and each is ACKed. A data byte beyond the last register is NACKed and discarded.
- R6: After a command, a repeated START with 0xD3 in single-byte mode returns the register at the offset, most significant bit first.
- R7: After a repeated START with 0xD3 in block mode, the slave first returns the register count, then the registers from index 0 in ascending order. A master NACK ends the read and releases SDA.
- R8: After reset, register 0 holds 0x03 and the other registers hold 0x00. The outputs follow register 0: `clk_en` = bits 1:0, `ss_en` = bit 2, `ss_depth` = bit 3 (1 selects -0.5 %, 0 selects -0.35 %).
- R9: A STOP or a START in any state aborts the transfer in progress and discards any partial byte. A START always returns the slave to address decode.
- R10: The slave begins pulling SDA low only while SCL is low.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock, at least 8x the SCL rate |
| rst_n | input | 1 | Active-low asynchronous reset |
| scl_i | input | 1 | Bus clock line as seen on the pin |
| sda_i | input | 1 | Bus data line as seen on the pin |
| sda_oe | output | 1 | Pull SDA low when 1, release when 0 |
| clk_en | output | 2 | Enable for each clock output pair |
| ss_en | output | 1 | Spread-spectrum enable |
| ss_depth | output | 1 | Spread depth: 1 = -0.5 %, 0 = -0.35 % |

## Verification
The bench builds the slave with four registers and keeps the default address and reset value. With four registers, a block write of five data bytes reaches the overrun NACK within a few bytes. The same setting makes the block read's leading count byte a small known value (4), and it lets a single-byte offset of 5 exercise the out-of-range NACK. SCL runs at 64 system clocks per period, which leaves room for the synchronizer delay and for SDA changes that must fall inside the SCL low phase.

// File: rtl/smb_cfg_slave.sv
module smb_cfg_slave #(
  parameter logic [6:0] DEV_ADDR  = 7'h69,
  parameter int         NUM_REGS  = 8,
  parameter logic [7:0] REG0_INIT = 8'h03
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       scl_i,
  input  logic       sda_i,
  output logic       sda_oe,
  output logic [1:0] clk_en,
  output logic       ss_en,
  output logic       ss_depth
);

  localparam int PW = 6;
  localparam int IW = (NUM_REGS > 1) ? $clog2(NUM_REGS) : 1;
  localparam logic [PW-1:0] NREG = PW'(NUM_REGS);
  localparam logic [PW-1:0] ONE  = PW'(1);

  typedef enum logic [2:0] {S_IDLE, S_ADDR, S_CMD, S_CNT, S_WR, S_RD, S_IGN} st_t;

  logic [2:0] scl_sh, sda_sh;
  logic       scl_s, scl_p, sda_s, sda_p;
  logic       scl_rise, scl_fall, start_c, stop_c;

  st_t           st, nxt;
  logic [3:0]    bcnt;
  logic [7:0]    sreg, tx, rd_byte;
  logic          oe, blk, cnt_first, m_nack;
  logic [4:0]    off;
  logic [PW-1:0] ptr;
  logic [7:0]    regs [NUM_REGS];

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      scl_sh <= 3'b111;
      sda_sh <= 3'b111;
    end else begin
      scl_sh <= {scl_sh[1:0], scl_i};
      sda_sh <= {sda_sh[1:0], sda_i};
    end

  assign scl_s    = scl_sh[1];
  assign scl_p    = scl_sh[2];
  assign sda_s    = sda_sh[1];
  assign sda_p    = sda_sh[2];
  assign scl_rise = scl_s & ~scl_p;
  assign scl_fall = ~scl_s & scl_p;
  assign start_c  = scl_s & scl_p & sda_p & ~sda_s;
  assign stop_c   = scl_s & scl_p & ~sda_p & sda_s;

  assign rd_byte = cnt_first ? 8'(NUM_REGS)
                 : (ptr < NREG) ? regs[ptr[IW-1:0]] : 8'h00;

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      st        <= S_IDLE;
      nxt       <= S_IDLE;
      bcnt      <= '0;
      sreg      <= '0;
      tx        <= '0;
      oe        <= 1'b0;
      blk       <= 1'b0;
      cnt_first <= 1'b0;
      m_nack    <= 1'b1;
      off       <= '0;
      ptr       <= '0;
      for (int i = 0; i < NUM_REGS; i++)
        regs[i] <= (i == 0) ? REG0_INIT : 8'h00;
    end else if (start_c) begin
      st   <= S_ADDR;
      bcnt <= '0;
      oe   <= 1'b0;
    end else if (stop_c) begin
      st   <= S_IDLE;
      bcnt <= '0;
      oe   <= 1'b0;
    end else if (st != S_IDLE) begin
      if (scl_rise) begin
        if (bcnt < 4'd8) sreg <= {sreg[6:0], sda_s};
        else             m_nack <= sda_s;
        if (bcnt < 4'd9) bcnt <= bcnt + 4'd1;
      end else if (scl_fall) begin
        if (bcnt == 4'd8) begin
          if (st == S_RD) oe <= 1'b0;
          else begin
            nxt <= S_IGN;
            case (st)
              S_ADDR:
                if (sreg[7:1] == DEV_ADDR) begin
                  oe <= 1'b1;
                  if (sreg[0]) begin
                    nxt       <= S_RD;
                    cnt_first <= blk;
                    ptr       <= blk ? '0 : {1'b0, off};
                  end else nxt <= S_CMD;
                end
              S_CMD:
                if (sreg[6:5] == 2'b00) begin
                  oe  <= 1'b1;
                  blk <= ~sreg[7];
                  off <= sreg[4:0];
                  ptr <= sreg[7] ? {1'b0, sreg[4:0]} : '0;
                  nxt <= sreg[7] ? S_WR : S_CNT;
                end
              S_CNT: begin
                oe  <= 1'b1;
                nxt <= S_WR;
              end
              S_WR: begin
                nxt <= S_WR;
                if (ptr < NREG) begin
                  oe                <= 1'b1;
                  regs[ptr[IW-1:0]] <= sreg;
                  ptr               <= blk ? ptr + ONE : NREG;
                end
              end
              default: nxt <= S_IGN;
            endcase
          end
        end else if (bcnt == 4'd9) begin
          bcnt <= '0;
          oe   <= 1'b0;
          if (st == S_RD && m_nack) st <= S_IGN;
          else begin
            st <= nxt;
            if (nxt == S_RD) begin
              tx <= rd_byte;
              oe <= ~rd_byte[7];
              if (cnt_first)       cnt_first <= 1'b0;
              else if (ptr < NREG) ptr <= ptr + ONE;
            end
          end
        end else if (st == S_RD && bcnt != 4'd0) begin
          tx <= {tx[6:0], 1'b0};
          oe <= ~tx[6];
        end
      end
    end

  assign sda_oe   = oe;
  assign clk_en   = regs[0][1:0];
  assign ss_en    = regs[0][2];
  assign ss_depth = regs[0][3];

  // R10
  sda_pull_scl_low_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(sda_oe) |-> !scl_s);

  // R9
  idle_released_chk: assert property (@(posedge clk) disable iff (!rst_n)
    st == S_IDLE |-> !sda_oe);

  // R1
  ignore_released_chk: assert property (@(posedge clk) disable iff (!rst_n)
    st == S_IGN |-> !sda_oe);

  // R3
  cfg_only_on_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable({clk_en, ss_en, ss_depth}) |-> $past(st) == S_WR);

  // R7
  bit_count_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
    bcnt <= 4'd9);

endmodule

// File: tb/sim_smb_cfg_slave.sv
module sim_smb_cfg_slave;
  localparam int Q = 16;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       scl = 1'b1;
  logic       sda_m = 1'b1;
  logic       sda_oe, ss_en, ss_depth;
  logic [1:0] clk_en;
  wire        sda_w = sda_m & ~sda_oe;
  int checks = 0;
  int fails  = 0;

  always #10 clk = ~clk;

  smb_cfg_slave #(.NUM_REGS(4)) u0 (
    .clk(clk), .rst_n(rst_n), .scl_i(scl), .sda_i(sda_w),
    .sda_oe(sda_oe), .clk_en(clk_en), .ss_en(ss_en), .ss_depth(ss_depth)
  );

  task automatic chk(input string req, input logic [7:0] act, input logic [7:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic w(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic bus_start();
    sda_m = 1'b1; w(Q); scl = 1'b1; w(Q); sda_m = 1'b0; w(Q); scl = 1'b0; w(Q);
  endtask

  task automatic bus_stop();
    sda_m = 1'b0; w(Q); scl = 1'b1; w(Q); sda_m = 1'b1; w(Q);
  endtask

  task automatic send(input logic [7:0] b, output logic ack);
    for (int i = 7; i >= 0; i--) begin
      sda_m = b[i]; w(Q); scl = 1'b1; w(2*Q); scl = 1'b0; w(Q);
    end
    sda_m = 1'b1; w(Q); scl = 1'b1; w(Q); ack = sda_w; w(Q); scl = 1'b0; w(Q);
  endtask

  task automatic recv(input logic nack, output logic [7:0] b);
    sda_m = 1'b1;
    for (int i = 7; i >= 0; i--) begin
      w(Q); scl = 1'b1; w(Q); b[i] = sda_w; w(Q); scl = 1'b0;
    end
    w(Q); sda_m = nack; w(Q); scl = 1'b1; w(2*Q); scl = 1'b0; w(Q); sda_m = 1'b1;
  endtask

  task automatic read_at(input logic [4:0] o, output logic [7:0] v);
    logic a;
    bus_start(); send(8'hD2, a); send({3'b100, o}, a);
    bus_start(); send(8'hD3, a); chk("R6 read addr ack", {7'd0, a}, 8'h00);
    recv(1'b1, v); bus_stop();
  endtask

  task automatic t_reset();
    chk("R8 clk_en default", {6'd0, clk_en}, 8'h03);
    chk("R8 ss_en default", {7'd0, ss_en}, 8'h00);
    chk("R8 ss_depth default", {7'd0, ss_depth}, 8'h00);
    chk("R8 sda released", {7'd0, sda_oe}, 8'h00);
  endtask

  task automatic t_byte_write();
    logic a;
    bus_start();
    send(8'hD2, a); chk("R1 addr ack", {7'd0, a}, 8'h00);
    send(8'h80, a); chk("R2 byte cmd ack", {7'd0, a}, 8'h00);
    send(8'h0D, a); chk("R4 data ack", {7'd0, a}, 8'h00);
    bus_stop();
    chk("R8 clk_en", {6'd0, clk_en}, 8'h01);
    chk("R8 ss_en", {7'd0, ss_en}, 8'h01);
    chk("R8 ss_depth", {7'd0, ss_depth}, 8'h01);
  endtask

  task automatic t_byte_read();
    logic [7:0] v;
    read_at(5'd0, v); chk("R6 readback reg0", v, 8'h0D);
  endtask

  task automatic t_block();
    logic a; logic [7:0] v;
    bus_start(); send(8'hD2, a); send(8'h1F, a);
    chk("R2 block cmd ack", {7'd0, a}, 8'h00);
    send(8'h03, a); chk("R5 count ack", {7'd0, a}, 8'h00);
    send(8'h11, a); chk("R5 data0 ack", {7'd0, a}, 8'h00);
    send(8'h22, a); send(8'h33, a);
    chk("R5 data2 ack", {7'd0, a}, 8'h00);
    bus_stop();
    bus_start(); send(8'hD2, a); send(8'h05, a);
    bus_start(); send(8'hD3, a);
    recv(1'b0, v); chk("R7 count byte", v, 8'h04);
    recv(1'b0, v); chk("R7 reg0", v, 8'h11);
    recv(1'b0, v); chk("R7 reg1", v, 8'h22);
    recv(1'b0, v); chk("R7 reg2", v, 8'h33);
    recv(1'b1, v); chk("R7 reg3", v, 8'h00);
    chk("R7 released after nack", {7'd0, sda_oe}, 8'h00);
    bus_stop();
    read_at(5'd2, v); chk("R2 byte offset read", v, 8'h33);
  endtask

  task automatic t_overrun();
    logic a; logic [7:0] v;
    bus_start(); send(8'hD2, a); send(8'h00, a); send(8'h05, a);
    send(8'hA1, a); send(8'hB2, a); send(8'hC3, a); send(8'hD4, a);
    chk("R5 last reg ack", {7'd0, a}, 8'h00);
    send(8'hEE, a); chk("R5 overrun nack", {7'd0, a}, 8'h01);
    bus_stop();
    read_at(5'd3, v); chk("R5 last reg kept", v, 8'hD4);
  endtask

  task automatic t_chip_select();
    logic a; logic [7:0] v;
    bus_start(); send(8'hD2, a);
    send(8'hA0, a); chk("R3 cs nack", {7'd0, a}, 8'h01);
    send(8'h0F, a); chk("R3 data after cs nack", {7'd0, a}, 8'h01);
    bus_stop();
    chk("R3 outputs unchanged", {4'd0, ss_depth, ss_en, clk_en}, 8'h01);
    read_at(5'd0, v); chk("R3 reg0 unchanged", v, 8'hA1);
  endtask

  task automatic t_wrong_addr();
    logic a;
    bus_start();
    send(8'hA4, a); chk("R1 foreign addr nack", {7'd0, a}, 8'h01);
    send(8'h80, a); chk("R1 ignored byte nack", {7'd0, a}, 8'h01);
    bus_stop();
  endtask

  task automatic t_byte_limits();
    logic a; logic [7:0] v;
    bus_start(); send(8'hD2, a); send(8'h81, a);
    send(8'h5A, a); chk("R4 first byte ack", {7'd0, a}, 8'h00);
    send(8'h66, a); chk("R4 second byte nack", {7'd0, a}, 8'h01);
    bus_stop();
    read_at(5'd1, v); chk("R4 reg1 written", v, 8'h5A);
    read_at(5'd2, v); chk("R4 reg2 untouched", v, 8'hC3);
    bus_start(); send(8'hD2, a); send(8'h85, a);
    chk("R4 oor cmd ack", {7'd0, a}, 8'h00);
    send(8'h99, a); chk("R4 oor data nack", {7'd0, a}, 8'h01);
    bus_stop();
  endtask

  task automatic t_abort();
    logic a; logic [7:0] v;
    bus_start(); send(8'hD2, a); send(8'h80, a);
    for (int i = 0; i < 4; i++) begin
      sda_m = 1'b1; w(Q); scl = 1'b1; w(2*Q); scl = 1'b0; w(Q);
    end
    bus_stop();
    read_at(5'd0, v); chk("R9 partial byte dropped", v, 8'hA1);
    bus_start(); send(8'hD2, a); send(8'h80, a);
    bus_start(); send(8'hD2, a); chk("R9 restart addr ack", {7'd0, a}, 8'h00);
    send(8'h82, a); send(8'h77, a);
    bus_stop();
    read_at(5'd2, v); chk("R9 write after restart", v, 8'h77);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    checks++; fails++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

  initial begin
    w(5); rst_n = 1'b1; w(5);
    t_reset();
    t_byte_write();
    t_byte_read();
    t_block();
    t_overrun();
    t_chip_select();
    t_wrong_addr();
    t_byte_limits();
    t_abort();
    w(10);
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule